// File: doc/BRIEF.md
# Divided Count-Down Interrupt Timer

This block is a local interrupt timer. A count-down counter is advanced by a prescaler that divides the bus clock by a programmable power of two. When software writes an initial count, the timer restarts. After that many divided periods the timer expires. The expiry is recorded in a small pending counter. The pending counter raises an interrupt request that carries a programmed vector, unless the timer's table entry is masked or the unit is software-disabled.

Software uses four registers behind a 2-bit register address:

| Address | Register | Access |
|---|---|---|
| 0 | Initial count | read/write |
| 1 | Current count | read-only |
| 2 | Divide configuration | read/write |
| 3 | Table entry | read/write |

The table entry holds three fields:

| Field | Bits | Meaning |
|---|---|---|
| Vector | [VEC_W-1:0] | Vector carried with the request |
| Mask | 16 | 1 masks delivery |
| Periodic | 17 | 1 selects periodic, 0 selects one-shot |

The consumer acknowledges a delivered request with `irq_ack_i`.

Top module: `lvt_timer`

## Requirements
- R1: The divide ratio is 2 raised to ((k+1) mod 8), where k = {div[3], div[1], div[0]}. Code 111 divides by 1, code 000 divides by 2 and code 110 divides by 128. Bit 2 has no effect. After an initial-count write of N at clock edge E, the expiry makes `irq_req_o` high after edge E + N·ratio.
- R2: Writing the initial count (address 0) restarts the count from the new value, drops any running period and clears the pending-expiry counter.
- R3: An initial count of zero stops the timer. The current count then reads 0, and no expiry occurs.
- R4: The current count (address 1) reads the number of divided periods still to run. It starts at N and falls by one every `ratio` clocks, rounding up.
- R5: If the periodic bit (entry bit 17) is set, the timer reloads the initial count on expiry. If it is clear, the timer expires once and stops.
- R6: Each expiry increments a pending counter, which saturates at 2^PEND_W−1. Each acknowledged request (`irq_req_o` and `irq_ack_i` high at a clock edge) decrements it. No request is raised while the mask bit (entry bit 16) is set, but pending expiries are kept.
- R7: While `sw_en_i` is low, the mask bit is forced to 1 (including on writes to the entry) and the pending counter is held at zero.
- R8: After reset the entry reads with only the mask bit set. The initial count, current count and divide register read 0, and no request is raised.
- R9: A divide-register write made while the timer runs takes effect at the next prescaler rollover. The period in progress finishes at the old ratio.
- R10: The initial-count and divide registers read back the last values written (divide bits [3:0]). Writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_en_i | input | 1 | Software enable of the unit |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write register address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read register address |
| rd_data_o | output | 32 | Read data (combinational) |
| irq_req_o | output | 1 | Interrupt request |
| irq_vec_o | output | VEC_W | Vector of the request |
| irq_ack_i | input | 1 | Request acknowledge |

## Verification
The bench builds the block with a 16-bit counter and a 2-bit pending counter. The narrow pending counter lets four expiries drive it into saturation at 3 within a few cycles. Ratios 1 and 2 keep expiry times short enough to count exactly. The divide-by-128 code is still exercised once end to end. A divide change placed one cycle after a restart puts the old-ratio rollover at a known edge, so the switch in ratio can be timed to the cycle.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 3;
  localparam int MASK_BIT = 16;
  localparam int PER_BIT  = 17;

  typedef enum logic [1:0] {
    A_INIT = 2'd0,
    A_CUR  = 2'd1,
    A_DIV  = 2'd2,
    A_ENT  = 2'd3
  } reg_addr_e;

  // shift = (k + 1) mod 8, k gathered from bits 3,1,0
  function automatic logic [SEL_W-1:0] div_shift(input logic [3:0] cfg);
    return {cfg[3], cfg[1:0]} + SEL_W'(1);
  endfunction
endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler
  import lt_pkg::*;
#(
  parameter int PRESC_W = (1 << SEL_W) - 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       run_i,
  input  logic [3:0] div_cfg_i,
  output logic       tick_o
);
  logic [SEL_W-1:0]   shift_q;
  logic [PRESC_W-1:0] presc_q;
  logic [PRESC_W:0]   ratio;
  logic [PRESC_W-1:0] ratio_m1;

  assign ratio    = (PRESC_W + 1)'(1) << shift_q;
  assign ratio_m1 = PRESC_W'(ratio - (PRESC_W + 1)'(1));
  assign tick_o   = run_i && !restart_i && (presc_q == ratio_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= div_shift(4'd0);
      presc_q <= '0;
    end else if (restart_i) begin
      shift_q <= div_shift(div_cfg_i);
      presc_q <= '0;
    end else if (run_i) begin
      if (presc_q == ratio_m1) begin
        presc_q <= '0;
        shift_q <= div_shift(div_cfg_i); // new ratio only at rollover
      end else begin
        presc_q <= presc_q + PRESC_W'(1);
      end
    end
  end

  p_presc_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_q <= ratio_m1);
  p_presc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && (presc_q != ratio_m1)) |=> $stable(shift_q));
endmodule

// File: rtl/lt_countdown.sv
module lt_countdown #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  assign expire_o = tick_i && !restart_i && (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;
  assign run_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= load_val_i;
      run_q <= (load_val_i != '0);
    end else if (tick_i) begin
      if (cnt_q == CNT_W'(1)) begin
        if (periodic_i && reload_val_i != '0) begin
          cnt_q <= reload_val_i;
        end else begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  p_restart_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cnt_q == $past(load_val_i));
  p_stop_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> cnt_q == '0);
  p_oneshot_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !periodic_i) |=> !run_q);
endmodule

// File: rtl/lt_pending.sv
module lt_pending #(
  parameter int PEND_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic deliver_en_i,
  input  logic ack_i,
  output logic req_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] pend_q;
  logic              dlv;

  assign req_o = (pend_q != '0) && deliver_en_i;
  assign dlv   = req_o && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (clr_i) begin
      pend_q <= '0;
    end else if (inc_i && !dlv) begin
      if (pend_q != PEND_MAX) pend_q <= pend_q + PEND_W'(1);
    end else if (dlv && !inc_i) begin
      pend_q <= pend_q - PEND_W'(1);
    end
  end

  p_pend_dec_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && dlv && !inc_i) |=> pend_q == $past(pend_q) - PEND_W'(1));
  p_pend_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && !dlv) |=> pend_q != '0);
endmodule

// File: rtl/lvt_timer.sv
module lvt_timer
  import lt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int VEC_W  = 8,
  parameter int PEND_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sw_en_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_req_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  input  logic              irq_ack_i
);
  logic [CNT_W-1:0] init_q;
  logic [3:0]       div_q;
  logic [VEC_W-1:0] vec_q;
  logic             mask_q, per_q;
  logic             wr_init, wr_div, wr_ent;
  logic             tick, run, expire;
  logic [CNT_W-1:0] cnt;

  assign wr_init = wr_en_i && (wr_addr_i == A_INIT);
  assign wr_div  = wr_en_i && (wr_addr_i == A_DIV);
  assign wr_ent  = wr_en_i && (wr_addr_i == A_ENT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      div_q  <= '0;
      vec_q  <= '0;
      mask_q <= 1'b1;
      per_q  <= 1'b0;
    end else begin
      if (wr_init) init_q <= wr_data_i[CNT_W-1:0];
      if (wr_div)  div_q  <= wr_data_i[3:0];
      if (wr_ent) begin
        vec_q  <= wr_data_i[VEC_W-1:0];
        per_q  <= wr_data_i[PER_BIT];
        mask_q <= wr_data_i[MASK_BIT] | !sw_en_i;
      end else if (!sw_en_i) begin
        mask_q <= 1'b1;
      end
    end
  end

  lt_prescaler u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (wr_init),
    .run_i     (run),
    .div_cfg_i (div_q),
    .tick_o    (tick)
  );

  lt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (wr_init),
    .load_val_i   (wr_data_i[CNT_W-1:0]),
    .reload_val_i (init_q),
    .tick_i       (tick),
    .periodic_i   (per_q),
    .cnt_o        (cnt),
    .run_o        (run),
    .expire_o     (expire)
  );

  lt_pending #(.PEND_W(PEND_W)) u_pend (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (wr_init || !sw_en_i),
    .inc_i        (expire),
    .deliver_en_i (sw_en_i && !mask_q),
    .ack_i        (irq_ack_i),
    .req_o        (irq_req_o)
  );

  assign irq_vec_o = vec_q;

  always_comb begin
    rd_data_o = '0;
    case (reg_addr_e'(rd_addr_i))
      A_INIT: rd_data_o[CNT_W-1:0] = init_q;
      A_CUR:  rd_data_o[CNT_W-1:0] = cnt;
      A_DIV:  rd_data_o[3:0]       = div_q;
      A_ENT: begin
        rd_data_o[VEC_W-1:0] = vec_q;
        rd_data_o[MASK_BIT]  = mask_q;
        rd_data_o[PER_BIT]   = per_q;
      end
      default: rd_data_o = '0;
    endcase
  end

  p_mask_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_i |=> mask_q);
  p_no_req_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q |-> !irq_req_o);
endmodule

// File: tb/lvt_timer_tb.sv
module lvt_timer_tb;
  localparam int CNT_W = 16;
  localparam int VEC_W = 8;
  localparam int PEND_W = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw_en = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic irq_req;
  logic [VEC_W-1:0] irq_vec;
  logic irq_ack = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lvt_timer #(.CNT_W(CNT_W), .VEC_W(VEC_W), .PEND_W(PEND_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sw_en_i(sw_en),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_req_o(irq_req), .irq_vec_o(irq_vec), .irq_ack_i(irq_ack)
  );

  localparam logic [31:0] MSK = 32'h1_0000;
  localparam logic [31:0] PER = 32'h2_0000;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  // edges after the init write until irq_req_o is seen high
  task automatic wait_req(output int cyc);
    cyc = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk); #1; cyc++;
      if (irq_req) break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); chk("R8 init", d, 0);
    rd(2'd1, d); chk("R8 cur", d, 0);
    rd(2'd2, d); chk("R8 div", d, 0);
    rd(2'd3, d); chk("R8 entry", d, MSK);
    chk("R8 req", {31'd0, irq_req}, 0);
  endtask

  task automatic t_ratio(input logic [3:0] code, input int n, input int ratio);
    int c;
    wr(2'd3, 32'h33);
    wr(2'd2, {28'd0, code});
    wr(2'd0, n);
    wait_req(c);
    chk($sformatf("R1 code %b", code), c, n * ratio);
    chk("R1 vector", {24'd0, irq_vec}, 32'h33);
    wr(2'd0, 0);
  endtask

  task automatic t_current;
    logic [31:0] d;
    wr(2'd3, MSK);
    wr(2'd2, 0);
    wr(2'd0, 10);
    repeat (6) @(posedge clk);
    #1; rd(2'd1, d); chk("R4 current count", d, 7);
    wr(2'd0, 0);
  endtask

  task automatic t_restart;
    int c;
    wr(2'd2, 32'hB);
    wr(2'd3, MSK);
    wr(2'd0, 3);
    repeat (5) @(posedge clk);
    wr(2'd0, 40);
    wr(2'd3, 32'h0);
    #1; chk("R2 pending cleared", {31'd0, irq_req}, 0);
    repeat (5) @(posedge clk);
    wr(2'd0, 6);
    wait_req(c);
    chk("R2 restart period", c, 6);
    wr(2'd0, 0);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    wr(2'd2, 32'hB);
    wr(2'd3, 32'h0);
    wr(2'd0, 20);
    repeat (5) @(posedge clk);
    wr(2'd0, 0);
    rd(2'd1, d); chk("R3 cur zero", d, 0);
    repeat (30) @(posedge clk);
    #1; chk("R3 no expiry", {31'd0, irq_req}, 0);
  endtask

  task automatic t_mode(input logic periodic, input int exp);
    int hits = 0;
    wr(2'd2, 32'hB);
    wr(2'd3, (periodic ? PER : 32'h0) | 32'h5A);
    @(negedge clk); irq_ack = 1'b1;
    wr(2'd0, 4);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #1;
      if (irq_req) begin
        hits++;
        chk("R5 vector", {24'd0, irq_vec}, 32'h5A);
      end
    end
    chk(periodic ? "R5 periodic count" : "R5 one-shot count", hits, exp);
    wr(2'd0, 0);
    irq_ack = 1'b0;
  endtask

  task automatic t_pending;
    int n = 0;
    wr(2'd2, 32'hB);
    wr(2'd3, MSK | PER);
    wr(2'd0, 3);
    repeat (9) @(posedge clk);
    wr(2'd3, MSK);
    repeat (5) @(posedge clk);
    #1; chk("R6 masked no req", {31'd0, irq_req}, 0);
    wr(2'd3, 32'h0);
    chk("R6 req after unmask", {31'd0, irq_req}, 1);
    @(negedge clk); irq_ack = 1'b1;
    while (irq_req && n < 10) begin
      @(posedge clk); #1; n++;
    end
    chk("R6 saturated deliveries", n, 3);
    irq_ack = 1'b0;
  endtask

  task automatic t_swoff;
    logic [31:0] d;
    wr(2'd2, 32'hB);
    wr(2'd3, 32'h0);
    wr(2'd0, 2);
    repeat (3) @(posedge clk);
    #1; chk("R7 req before disable", {31'd0, irq_req}, 1);
    @(negedge clk); sw_en = 1'b0;
    @(posedge clk); #1;
    rd(2'd3, d); chk("R7 mask forced", d & MSK, MSK);
    chk("R7 req off", {31'd0, irq_req}, 0);
    wr(2'd3, 32'h0);
    rd(2'd3, d); chk("R7 write keeps mask", d & MSK, MSK);
    @(negedge clk); sw_en = 1'b1;
    wr(2'd3, 32'h0);
    #1; chk("R7 pending cleared", {31'd0, irq_req}, 0);
  endtask

  task automatic t_divchg;
    int c;
    wr(2'd3, 32'h0);
    wr(2'd2, 0);
    wr(2'd0, 4);
    wr(2'd2, 32'hB);
    wait_req(c);
    chk("R9 divide change timing", c + 1, 5);
    wr(2'd0, 0);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(2'd2, 32'h5);
    rd(2'd2, d); chk("R10 div readback", d, 5);
    wr(2'd3, MSK);
    wr(2'd0, 16'hBEEF);
    rd(2'd0, d); chk("R10 init readback", d, 32'hBEEF);
    wr(2'd0, 0);
    wr(2'd1, 32'h55);
    rd(2'd1, d); chk("R10 cur write ignored", d, 0);
    rd(2'd0, d); chk("R10 init unchanged", d, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1; rst_ni = 1'b1;
        t_reset();
        t_ratio(4'b1011, 7, 1);
        t_ratio(4'b0000, 5, 2);
        t_ratio(4'b0001, 3, 4);
        t_ratio(4'b0100, 4, 2);
        t_ratio(4'b1010, 2, 128);
        t_current();
        t_restart();
        t_zero();
        t_mode(1'b1, 10);
        t_mode(1'b0, 1);
        t_pending();
        t_swoff();
        t_divchg();
        t_readback();
      end
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule